// File: doc/BRIEF.md
# Push-Button Triggered Color Phase Sequencer

This block turns one press of a mechanical push button into one timed pass over three color outputs. Each accepted press drives red, then green, then blue. Each color is high for one third of a second. After blue all three outputs return low and the block waits for the next press. Contact bounce on either edge of the button is filtered, so one physical press gives exactly one pass.

Everything runs on one system clock. Two parameterized dividers make single-cycle enables from that clock: a fast one (1 kHz at the default setting) clocks the button filter, and a slow one (3 Hz at the default setting) paces the color phases. Two separate state machines cooperate. The filter machine synchronizes the raw button through a flop chain and accepts a new level only after it has stayed steady long enough. It then emits a one-cycle trigger on the accepted rising edge. The phase machine arms on that trigger and starts red on the next slow enable. From there it advances one color on every slow enable.

Top module: `press_rgb_sequencer`

## Requirements
- R1: While reset is low, and on the first cycle after reset rises, `red_o`, `grn_o` and `blu_o` are all 0 and the block is idle.
- R2: A new button level is accepted only after the synchronized input has differed from the accepted level on `STABLE_TICKS` consecutive filter enables. A press shorter than two filter periods starts no pass.
- R3: Each accepted press starts exactly one pass, even when the press and the release each bounce.
- R4: A pass always runs red, then green, then blue, and then all outputs go low.
- R5: Each color stays high for exactly `PHASE_DIV` clock cycles.
- R6: Red rises on the first slow enable after the trigger. Measured from the start of a clean press, this takes at least (`STABLE_TICKS`-1)·`DEB_DIV` and at most 6+(`STABLE_TICKS`+1)·`DEB_DIV`+`PHASE_DIV` cycles.
- R7: At no time is more than one of the three color outputs high.
- R8: A press accepted while a pass is running is ignored: no second pass follows.
- R9: Holding the button down continuously starts no further passes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_btn | input | 1 | Raw push-button level, asynchronous and bouncing, 1 = pressed |
| red_o | output | 1 | Red phase active |
| grn_o | output | 1 | Green phase active |
| blu_o | output | 1 | Blue phase active |

## Verification
The hardest case to reach from the ports is a button edge that is accepted while the phase machine is busy. This requires the filter to see a clean press that lands wholly inside one color phase. The bench first starts a pass. It waits until green is visible at the outputs, then gives a second press long enough to pass the filter and releases it before blue ends. It then watches the idle outputs for three full slow periods. Bounce is produced by toggling the button every cycle for several filter periods around both edges. The bench then counts red rising edges to confirm that only one pass followed.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE  = 3'd0,
        SEQ_ARMED = 3'd1,
        SEQ_RED   = 3'd2,
        SEQ_GRN   = 3'd3,
        SEQ_BLU   = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       red;
        logic       grn;
        logic       blu;
    } seq_regs_t;

endpackage

// File: rtl/pcs_tick_div.sv
module pcs_tick_div #(
    parameter int DIV = 100000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } div_regs_t;

    div_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (r_q.cnt == CW'(DIV - 1)) begin
            r_d.cnt  = '0;
            r_d.tick = 1'b1;
        end else begin
            r_d.cnt  = r_q.cnt + 1'b1;
            r_d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tick_o = r_q.tick;
endmodule

// File: rtl/pcs_debounce.sv
module pcs_debounce #(
    parameter int STABLE_TICKS = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic btn_i,
    output logic level_o,
    output logic press_o
);
    localparam int CW = $clog2(STABLE_TICKS + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   level;
        logic [CW-1:0]          cnt;
        logic                   press;
    } deb_regs_t;

    deb_regs_t r_d, r_q;
    logic      samp;

    assign samp = r_q.sync[SYNC_STAGES-1];

    always_comb begin
        r_d       = r_q;
        r_d.sync  = {r_q.sync[SYNC_STAGES-2:0], btn_i};
        r_d.press = 1'b0;
        if (tick_i) begin
            if (samp != r_q.level) begin
                if (r_q.cnt == CW'(STABLE_TICKS - 1)) begin
                    r_d.level = samp;
                    r_d.cnt   = '0;
                    r_d.press = samp;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end else begin
                r_d.cnt = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign level_o = r_q.level;
    assign press_o = r_q.press;
endmodule

// File: rtl/pcs_phase_seq.sv
module pcs_phase_seq
    import pcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic trig_i,
    output logic red_o,
    output logic grn_o,
    output logic blu_o
);
    seq_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            SEQ_IDLE:  if (trig_i) r_d.state = SEQ_ARMED;
            SEQ_ARMED: if (tick_i) r_d.state = SEQ_RED;
            SEQ_RED:   if (tick_i) r_d.state = SEQ_GRN;
            SEQ_GRN:   if (tick_i) r_d.state = SEQ_BLU;
            SEQ_BLU:   if (tick_i) r_d.state = SEQ_IDLE;
            default:   r_d.state = SEQ_IDLE;
        endcase
        r_d.red = (r_d.state == SEQ_RED);
        r_d.grn = (r_d.state == SEQ_GRN);
        r_d.blu = (r_d.state == SEQ_BLU);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{state: SEQ_IDLE, red: 1'b0, grn: 1'b0, blu: 1'b0};
        else        r_q <= r_d;
    end

    assign red_o = r_q.red;
    assign grn_o = r_q.grn;
    assign blu_o = r_q.blu;
endmodule

// File: rtl/press_rgb_sequencer.sv
module press_rgb_sequencer #(
    parameter int DEB_DIV      = 100000,
    parameter int PHASE_DIV    = 33333333,
    parameter int STABLE_TICKS = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_btn,
    output logic red_o,
    output logic grn_o,
    output logic blu_o
);
    logic deb_tick_w;
    logic ph_tick_w;
    logic level_w;
    logic trig_w;

    pcs_tick_div #(.DIV(DEB_DIV)) u_deb_div (
        .clk(clk), .rst_n(rst_n), .tick_o(deb_tick_w)
    );

    pcs_tick_div #(.DIV(PHASE_DIV)) u_ph_div (
        .clk(clk), .rst_n(rst_n), .tick_o(ph_tick_w)
    );

    pcs_debounce #(
        .STABLE_TICKS(STABLE_TICKS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_deb (
        .clk(clk), .rst_n(rst_n), .tick_i(deb_tick_w), .btn_i(start_btn),
        .level_o(level_w), .press_o(trig_w)
    );

    pcs_phase_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(ph_tick_w), .trig_i(trig_w),
        .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
    );
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
    parameter int PHASE_DIV = 33333333
) (
    input logic clk,
    input logic rst_n,
    input logic red,
    input logic grn,
    input logic blu,
    input logic trig,
    input logic ph_tick
);
    localparam int LW = $clog2(PHASE_DIV + 2);

    logic [2:0]    rgb;
    logic [2:0]    prev_q;
    logic [LW-1:0] len_q;
    logic [LW-1:0] len_now;

    assign rgb     = {red, grn, blu};
    assign len_now = (rgb == prev_q) ? len_q + 1'b1 : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
            len_q  <= '0;
        end else begin
            prev_q <= rgb;
            len_q  <= len_now;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> rgb == 3'b000); // R1
    AST_TRIG_PULSE: assert property (@(posedge clk) disable iff (!rst_n) trig |=> !trig); // R3
    AST_RED_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(red) |-> $past(rgb) == 3'b000); // R4
    AST_GRN_AFTER_RED: assert property (@(posedge clk) disable iff (!rst_n) $rose(grn) |-> $past(red)); // R4
    AST_BLU_AFTER_GRN: assert property (@(posedge clk) disable iff (!rst_n) $rose(blu) |-> $past(grn)); // R4
    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n) $fell(blu) |-> rgb == 3'b000); // R4
    AST_PHASE_LEN: assert property (@(posedge clk) disable iff (!rst_n) (rgb != 3'b000) |-> len_now < LW'(PHASE_DIV)); // R5
    AST_STEP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) (rgb != prev_q) |-> $past(ph_tick)); // R6
    AST_ONE_COLOR: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(rgb)); // R7
endmodule

bind press_rgb_sequencer pcs_checker #(.PHASE_DIV(PHASE_DIV)) u_chk (
    .clk(clk), .rst_n(rst_n), .red(red_o), .grn(grn_o), .blu(blu_o),
    .trig(trig_w), .ph_tick(ph_tick_w)
);

// File: tb/press_rgb_sequencer_bench.sv
module press_rgb_sequencer_bench;
    localparam int DEB_DIV   = 4;
    localparam int PHASE_DIV = 200;
    localparam int STABLE    = 3;
    localparam int LAT_MIN   = (STABLE - 1) * DEB_DIV;
    localparam int LAT_MAX   = 6 + (STABLE + 1) * DEB_DIV + PHASE_DIV;
    localparam int VEC_N     = 5;
    localparam int W_TAB [VEC_N] = '{3, 6, 24, 60, 150};
    localparam bit E_TAB [VEC_N] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_btn = 1'b0;
    logic red_o, grn_o, blu_o;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int red_rises = 0;
    bit multi_hot = 1'b0;
    bit done = 1'b0;
    logic red_prev = 1'b0;

    always #2 clk = ~clk;

    press_rgb_sequencer #(
        .DEB_DIV(DEB_DIV), .PHASE_DIV(PHASE_DIV), .STABLE_TICKS(STABLE), .SYNC_STAGES(2)
    ) u_press_rgb_sequencer (
        .clk(clk), .rst_n(rst_n), .start_btn(start_btn),
        .red_o(red_o), .grn_o(grn_o), .blu_o(blu_o)
    );

    always @(negedge clk) begin
        cyc <= cyc + 1;
        red_prev <= red_o;
        if (rst_n && red_o && !red_prev) red_rises <= red_rises + 1;
        if ((32'(red_o) + 32'(grn_o) + 32'(blu_o)) > 1) multi_hot <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic press(input int width);
        @(negedge clk) start_btn = 1'b1;
        repeat (width) @(negedge clk);
        start_btn = 1'b0;
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Starts at the first negedge with red high; counts each phase length.
    task automatic measure_run();
        int len;
        len = 0;
        while (red_o && len < 4 * PHASE_DIV) begin len++; @(negedge clk); end
        check(len == PHASE_DIV, "R5 red length", len, PHASE_DIV);
        check(grn_o && !blu_o && !red_o, "R4 green follows red", {red_o, grn_o, blu_o}, 3'b010);
        len = 0;
        while (grn_o && len < 4 * PHASE_DIV) begin len++; @(negedge clk); end
        check(len == PHASE_DIV, "R5 green length", len, PHASE_DIV);
        check(blu_o && !red_o && !grn_o, "R4 blue follows green", {red_o, grn_o, blu_o}, 3'b001);
        len = 0;
        while (blu_o && len < 4 * PHASE_DIV) begin len++; @(negedge clk); end
        check(len == PHASE_DIV, "R5 blue length", len, PHASE_DIV);
        check({red_o, grn_o, blu_o} == 3'b000, "R4 idle after blue", {red_o, grn_o, blu_o}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int t0, seen, base;
        idle_wait(5);
        check({red_o, grn_o, blu_o} == 3'b000, "R1 outputs low in reset", {red_o, grn_o, blu_o}, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check({red_o, grn_o, blu_o} == 3'b000, "R1 outputs low after reset", {red_o, grn_o, blu_o}, 0);
        idle_wait(20);

        // Table walk: pulse width versus whether a pass follows (R2, R3, R6)
        for (int v = 0; v < VEC_N; v++) begin
            base = red_rises;
            t0 = cyc;
            seen = 0;
            fork
                press(W_TAB[v]);
                begin
                    while (!red_o && (cyc - t0) <= LAT_MAX + 2) @(negedge clk);
                    seen = red_o;
                end
            join_any
            wait fork;
            if (E_TAB[v]) begin
                check(seen == 1, "R2 accepted press starts pass", seen, 1);
                check((cyc - t0) >= LAT_MIN && (cyc - t0) <= LAT_MAX, "R6 start latency",
                      cyc - t0, LAT_MAX);
                if (red_o) measure_run();
            end else begin
                check(seen == 0, "R2 short pulse rejected", seen, 0);
            end
            idle_wait(3 * PHASE_DIV);
            check(red_rises - base == 32'(E_TAB[v]), "R3 passes per press", red_rises - base,
                  32'(E_TAB[v]));
        end

        // Bounce on both edges gives one pass (R3)
        base = red_rises;
        for (int i = 0; i < 20; i++) @(negedge clk) start_btn = ~start_btn;
        @(negedge clk) start_btn = 1'b1;
        idle_wait(40);
        for (int i = 0; i < 20; i++) @(negedge clk) start_btn = ~start_btn;
        @(negedge clk) start_btn = 1'b0;
        idle_wait(5 * PHASE_DIV);
        check(red_rises - base == 1, "R3 bouncing press one pass", red_rises - base, 1);

        // Press during a pass is ignored (R8)
        base = red_rises;
        press(40);
        while (!grn_o) @(negedge clk);
        press(40);
        while (grn_o || blu_o) @(negedge clk);
        idle_wait(3 * PHASE_DIV);
        check(red_rises - base == 1, "R8 press while busy ignored", red_rises - base, 1);
        check({red_o, grn_o, blu_o} == 3'b000, "R8 idle after ignored press",
              {red_o, grn_o, blu_o}, 0);

        // Holding gives a single pass (R9)
        base = red_rises;
        @(negedge clk) start_btn = 1'b1;
        idle_wait(7 * PHASE_DIV);
        check(red_rises - base == 1, "R9 held button one pass", red_rises - base, 1);
        check({red_o, grn_o, blu_o} == 3'b000, "R9 idle while held", {red_o, grn_o, blu_o}, 0);
        start_btn = 1'b0;
        idle_wait(40);

        // Reset in the middle of a pass (R1)
        press(30);
        while (!grn_o) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({red_o, grn_o, blu_o} == 3'b000, "R1 reset aborts pass", {red_o, grn_o, blu_o}, 0);
        @(negedge clk) rst_n = 1'b1;
        idle_wait(3 * PHASE_DIV);
        check({red_o, grn_o, blu_o} == 3'b000, "R1 stays idle after reset",
              {red_o, grn_o, blu_o}, 0);

        check(!multi_hot, "R7 at most one color high", 32'(multi_hot), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule